// File: doc/BRIEF.md
# SCL Boost Pullup Controller

This block sits beside an I2C master's bit engine and decides, cycle by cycle, when the current-source pullup on SCL may be switched on to speed up rising clock edges during high-speed transfers. The bit engine reports protocol milestones as single-cycle pulses: master code byte sent, the following not-acknowledge slot finished, repeated START issued, acknowledge slot finished, and STOP issued. The block also receives the SCL level after it has passed through a synchronizer. From these inputs it produces a registered boost enable. It also tells the bit engine whether high-speed bit timing is in force.

The boost is never on during the slow-speed preamble. After the preamble, and again after every repeated START and every acknowledge slot, the boost is dropped and the block waits until SCL is seen high. A high SCL means every device has let go of the clock. Only then is the boost enabled again. This leaves slaves free to stretch the low period at those points. If SCL stays low for a programmable number of cycles while the block is waiting, a timeout flag is raised and the boost stays off until the next re-arming event. A STOP returns the block to its idle state.

Top module: `scl_boost_ctrl`

## Requirements
- R1: A synchronous active-high reset drives boost_en, hs_active and stretch_timeout to 0 on the clock edge after it is sampled.
- R2: From the master-code pulse up to and including the edge that samples the not-acknowledge pulse, boost_en stays 0 whatever the SCL level.
- R3: After the not-acknowledge pulse that follows a master code, boost_en goes to 1 on the first edge at which scl_in is sampled high. This happens before any repeated START.
- R4: A repeated-START pulse after the preamble, or during high-speed operation, forces boost_en to 0 on the next edge. Re-enabling then follows R3's rule.
- R5: An acknowledge-slot pulse during high-speed operation forces boost_en to 0 on the next edge. boost_en returns to 1 on the first later edge where scl_in is high.
- R6: A STOP pulse clears boost_en, hs_active and stretch_timeout on the next edge. Repeated-START, acknowledge or SCL-high inputs then leave all three at 0 until a new master code and not-acknowledge pair completes.
- R7: While idle, acknowledge, repeated-START and not-acknowledge pulses have no effect: all three outputs stay 0.
- R8: If scl_in is sampled low on TIMEOUT_CYCLES consecutive edges after a re-arming event, stretch_timeout becomes 1 on the last of those edges. boost_en then stays 0 even when SCL goes high. The flag clears at the next re-arming event or at STOP.
- R9: hs_active rises on the edge after the repeated START that follows the preamble and stays 1 until STOP.
- R10: When STOP coincides with any other event pulse, STOP wins: all outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_mcode_sent | input | 1 | Pulse: high-speed master code byte transmitted |
| ev_nack_done | input | 1 | Pulse: not-acknowledge slot completed |
| ev_rstart | input | 1 | Pulse: repeated START issued |
| ev_ack_done | input | 1 | Pulse: acknowledge or not-acknowledge slot completed |
| ev_stop | input | 1 | Pulse: STOP issued |
| scl_in | input | 1 | Synchronized SCL level |
| boost_en | output | 1 | Enable for the SCL current-source pullup |
| hs_active | output | 1 | High-speed bit timing in use |
| stretch_timeout | output | 1 | SCL held low past the timeout while waiting to re-enable |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 4. At that value the timeout boundary is tested directly: three low samples after an acknowledge leave the flag clear, and the fourth sets it. The same short window lets a timeout be triggered during the preamble-armed phase and then cleared by STOP. A table of vectors walks the block through idle, preamble, high-speed and STOP phases, including coincident STOP and acknowledge pulses.

// File: rtl/scl_boost_pkg.sv
package scl_boost_pkg;
  // Bus phase as seen by the boost controller.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // no high-speed activity
    PH_MCODE = 2'd1,  // master code sent, awaiting the NACK slot
    PH_ARMED = 2'd2,  // preamble complete, awaiting repeated START
    PH_HS    = 2'd3   // high-speed transfer in progress
  } phase_e;
endpackage

// File: rtl/hs_phase_fsm.sv
module hs_phase_fsm
  import scl_boost_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ev_mcode_sent,
  input  logic   ev_nack_done,
  input  logic   ev_rstart,
  input  logic   ev_ack_done,
  input  logic   ev_stop,
  output phase_e phase,
  output logic   hs_active,
  output logic   arm
);
  phase_e phase_q, phase_d;
  logic   hs_q;
  logic   eligible;

  assign eligible = (phase_q == PH_ARMED) || (phase_q == PH_HS);

  always_comb begin
    phase_d = phase_q;
    if (ev_stop) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:  if (ev_mcode_sent) phase_d = PH_MCODE;
        PH_MCODE: if (ev_nack_done)  phase_d = PH_ARMED;
        PH_ARMED: if (ev_rstart)     phase_d = PH_HS;
        PH_HS:    phase_d = PH_HS;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  // Re-arming event: end of preamble, or a repeated START / ack slot
  // once the preamble has finished.
  always_comb begin
    arm = 1'b0;
    if (!ev_stop) begin
      if (phase_q == PH_MCODE && ev_nack_done) arm = 1'b1;
      if (eligible && (ev_rstart || ev_ack_done)) arm = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      hs_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hs_q    <= (phase_d == PH_HS);
    end
  end

  assign phase     = phase_q;
  assign hs_active = hs_q;
endmodule

// File: rtl/stretch_timer.sv
module stretch_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/boost_gate.sv
module boost_gate (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic quit,
  input  logic scl_in,
  input  logic expired,
  output logic boost_en,
  output logic waiting,
  output logic timeout_flag
);
  logic boost_q, wait_q, tmo_q;

  always_ff @(posedge clk) begin
    if (rst || quit) begin
      boost_q <= 1'b0;
      wait_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else if (arm) begin
      boost_q <= 1'b0;
      wait_q  <= 1'b1;
      tmo_q   <= 1'b0;
    end else if (wait_q) begin
      if (scl_in) begin
        boost_q <= 1'b1;
        wait_q  <= 1'b0;
      end else if (expired) begin
        tmo_q   <= 1'b1;
        wait_q  <= 1'b0;
      end
    end
  end

  assign boost_en     = boost_q;
  assign waiting      = wait_q;
  assign timeout_flag = tmo_q;
endmodule

// File: rtl/scl_boost_ctrl.sv
module scl_boost_ctrl
  import scl_boost_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_mcode_sent,
  input  logic ev_nack_done,
  input  logic ev_rstart,
  input  logic ev_ack_done,
  input  logic ev_stop,
  input  logic scl_in,
  output logic boost_en,
  output logic hs_active,
  output logic stretch_timeout
);
  phase_e phase;
  logic   arm, waiting, expired, timer_run;

  hs_phase_fsm u_phase (
    .clk           (clk),
    .rst           (rst),
    .ev_mcode_sent (ev_mcode_sent),
    .ev_nack_done  (ev_nack_done),
    .ev_rstart     (ev_rstart),
    .ev_ack_done   (ev_ack_done),
    .ev_stop       (ev_stop),
    .phase         (phase),
    .hs_active     (hs_active),
    .arm           (arm)
  );

  // Count only while waiting for release and SCL is still held low.
  assign timer_run = waiting && !scl_in && !arm && !ev_stop
                     && (phase != PH_IDLE);

  stretch_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (arm || ev_stop),
    .run     (timer_run),
    .expired (expired)
  );

  boost_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .arm          (arm),
    .quit         (ev_stop),
    .scl_in       (scl_in),
    .expired      (expired),
    .boost_en     (boost_en),
    .waiting      (waiting),
    .timeout_flag (stretch_timeout)
  );
endmodule

// File: rtl/scl_boost_chk.sv
module scl_boost_chk (
  input logic clk,
  input logic rst,
  input logic ev_rstart,
  input logic ev_ack_done,
  input logic ev_stop,
  input logic scl_in,
  input logic boost_en,
  input logic hs_active,
  input logic stretch_timeout
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!boost_en && !hs_active && !stretch_timeout));

  // R3
  boost_needs_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(boost_en) |-> $past(scl_in));

  // R4
  hs_event_drops_boost_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_active && (ev_rstart || ev_ack_done) && !ev_stop) |=> !boost_en);

  // R6
  stop_clears_all_chk: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (!boost_en && !hs_active && !stretch_timeout));

  // R8
  timeout_blocks_boost_chk: assert property (@(posedge clk) disable iff (rst)
    stretch_timeout |-> !boost_en);

  // R9
  hs_rise_from_rstart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_active) |-> ($past(ev_rstart) && !$past(ev_stop)));
endmodule

bind scl_boost_ctrl scl_boost_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .ev_rstart       (ev_rstart),
  .ev_ack_done     (ev_ack_done),
  .ev_stop         (ev_stop),
  .scl_in          (scl_in),
  .boost_en        (boost_en),
  .hs_active       (hs_active),
  .stretch_timeout (stretch_timeout)
);

// File: tb/tb_scl_boost_ctrl.sv
module tb_scl_boost_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 4;
  localparam int NV = 28;

  // bits: [8]mcode [7]nack [6]rstart [5]ack [4]stop [3]scl | [2]boost [1]hs [0]tmo
  localparam logic [8:0] VEC [NV] = '{
    9'b00010_1_000, // 0  R7 ack while idle
    9'b00100_1_000, // 1  R7 rstart while idle
    9'b01000_1_000, // 2  R7 nack while idle
    9'b10000_1_000, // 3  R2 master code
    9'b00000_1_000, // 4  R2 scl high, still preamble
    9'b01000_0_000, // 5  R2 nack slot, arms
    9'b00000_0_000, // 6  R3 scl still low
    9'b00000_1_100, // 7  R3 scl high -> boost
    9'b00100_1_010, // 8  R4 R9 repeated start
    9'b00000_1_110, // 9  R4 re-enable
    9'b00010_1_010, // 10 R5 ack drops boost
    9'b00000_0_010, // 11 R5 stretched
    9'b00000_1_110, // 12 R5 released
    9'b00010_0_010, // 13 R8 ack, scl low
    9'b00000_0_010, // 14 R8 low 1
    9'b00000_0_010, // 15 R8 low 2
    9'b00000_0_010, // 16 R8 low 3
    9'b00000_0_011, // 17 R8 low 4 -> timeout
    9'b00000_1_011, // 18 R8 scl high, boost held off
    9'b00100_1_010, // 19 R8 rearm clears flag
    9'b00000_1_110, // 20 R4 boost back
    9'b00011_1_000, // 21 R10 R6 stop with ack
    9'b00100_1_000, // 22 R6 rstart after stop
    9'b00010_1_000, // 23 R6 ack after stop
    9'b10000_1_000, // 24 R2 new master code
    9'b01000_1_000, // 25 R2 nack, arms
    9'b00000_1_100, // 26 R3 boost before Sr
    9'b00001_1_000  // 27 R6 stop
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_mcode_sent = 1'b0, ev_nack_done = 1'b0, ev_rstart = 1'b0;
  logic ev_ack_done = 1'b0, ev_stop = 1'b0, scl_in = 1'b1;
  logic boost_en, hs_active, stretch_timeout;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_boost_ctrl #(.TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst(rst),
    .ev_mcode_sent(ev_mcode_sent), .ev_nack_done(ev_nack_done),
    .ev_rstart(ev_rstart), .ev_ack_done(ev_ack_done), .ev_stop(ev_stop),
    .scl_in(scl_in),
    .boost_en(boost_en), .hs_active(hs_active), .stretch_timeout(stretch_timeout)
  );

  function automatic string vtag(int i);
    case (i)
      0, 1, 2:            return "R7";
      3, 4, 5, 24, 25:    return "R2";
      6, 7, 26:           return "R3";
      8:                  return "R9";
      9, 20:              return "R4";
      10, 11, 12:         return "R5";
      21:                 return "R10";
      22, 23, 27:         return "R6";
      default:            return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {boost_en, hs_active, stretch_timeout};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {boost,hs,tmo} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic [4:0] ev, logic scl);
    @(negedge clk);
    {ev_mcode_sent, ev_nack_done, ev_rstart, ev_ack_done, ev_stop} = ev;
    scl_in = scl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 3'b000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8:4], VEC[i][3]);
      check(vtag(i), VEC[i][2:0]);
    end

    // R1: reset in the middle of high-speed operation
    step(5'b10000, 1'b1);
    step(5'b01000, 1'b1);
    step(5'b00100, 1'b1);
    step(5'b00000, 1'b1);
    check("R4", 3'b110);
    @(negedge clk);
    rst = 1'b1;
    {ev_mcode_sent, ev_nack_done, ev_rstart, ev_ack_done, ev_stop} = '0;
    @(posedge clk);
    #1;
    check("R1", 3'b000);
    @(negedge clk);
    rst = 1'b0;

    // R8 timeout in the armed preamble phase, then R6 stop clears it
    step(5'b10000, 1'b0);
    step(5'b01000, 1'b0);
    for (int k = 0; k < TMO - 1; k++) step(5'b00000, 1'b0);
    check("R8", 3'b000);
    step(5'b00000, 1'b0);
    check("R8", 3'b001);
    step(5'b00001, 1'b0);
    check("R6", 3'b000);
    step(5'b00000, 1'b1);
    check("R6", 3'b000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule